// File: doc/BRIEF.md
# Delta-Sigma Converter Bring-Up and Streaming Sequencer

This block is an SPI host that runs a fixed command script against an external 24-bit delta-sigma converter. A start request makes it reset the converter and write a block of six configuration registers. It then reads the six registers back and compares them with the values it wrote. If all six match, it issues the command that starts continuous conversion. If any byte differs, it latches a sticky error and goes no further.

Once conversions run, each falling edge of the converter's active-low data-ready line starts a read. The block fetches three data bytes and shows them as a 24-bit two's-complement sample, together with a one-cycle valid strobe. A stop request, taken between reads, sends the standby command.

Every command travels in its own chip-select frame. Between frames, chip select stays high for a programmable minimum time.

Top module: `adc_seq_host`

## Requirements
- R1: After reset, cs_n is 1, sclk is 0, and sample_valid, cfg_error and streaming are all 0.
- R2: The link uses SPI mode 1. sclk is 0 whenever cs_n is high. MOSI changes only at rising sclk edges, MSB first. MISO is sampled at falling sclk edges, MSB first.
- R3: A start_req in idle (with cfg_error clear) sends a frame holding only the byte 0x06.
- R4: The next frame is exactly 0x42, 0x05, 0x12, 0x0A, 0x14, 0x12, 0x07, 0xF0.
- R5: The next frame is 0x22, 0x05 and then six 0x00 bytes. The six MISO bytes returned for the 0x00 bytes are compared, in order, with 0x12, 0x0A, 0x14, 0x12, 0x07, 0xF0.
- R6: When all six compare equal, a frame holding only 0x08 follows, and streaming becomes 1 once that frame ends.
- R7: While streaming, a falling edge on drdy_n (after a two-flop synchronizer) causes a frame of 0x12, 0x00, 0x00, 0x00. When streaming is 0, drdy_n edges start no frame.
- R8: The three MISO bytes returned after 0x12 are joined first byte highest into `sample`. sample_valid is high for exactly one clock, while cs_n is still low in that frame.
- R9: A readback mismatch sets cfg_error. cfg_error stays set until reset, no 0x08 frame is sent, and later start_req pulses send nothing.
- R10: While streaming, a stop_req (even one raised during a read frame) lets any read in progress finish and then sends a frame holding only 0x0A, after which streaming is 0. A stop_req while streaming is 0 sends nothing.
- R11: cs_n stays high for at least CS_GAP sclk periods (2*CLK_DIV*CS_GAP clocks) between any two frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_req | input | 1 | Pulse: begin the bring-up script |
| stop_req | input | 1 | Pulse: send the standby command after the current read |
| drdy_n | input | 1 | Converter data-ready, active low, asynchronous |
| miso | input | 1 | Serial data from the converter |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data to the converter |
| cs_n | output | 1 | Active-low chip select, one frame per command |
| sample | output | 24 | Last conversion result, two's complement |
| sample_valid | output | 1 | One-cycle strobe when `sample` updates |
| cfg_error | output | 1 | Sticky configuration readback mismatch |
| streaming | output | 1 | Conversions running, data-ready edges serviced |

## Verification
The script position cannot be seen directly at the ports. A wrong position shows up in the very next chip-select frame, as a byte sequence or length that differs from the expected one, so the frame-level scoreboard catches it at the rising edge of cs_n that closes that frame. A faulty bit counter or a wrong MISO sampling edge gives a sample that differs from the value the converter model returned, and this is seen at the strobe that ends the same read. A faulty error latch or stop latch becomes visible as one frame too many or too few within a few hundred clocks of the stimulus, and the bench watches for that quiet window.

// File: rtl/adc_seq_host.sv
module adc_seq_host #(
  parameter int CLK_DIV = 4,
  parameter int CS_GAP  = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_req,
  input  logic        stop_req,
  input  logic        drdy_n,
  input  logic        miso,
  output logic        sclk,
  output logic        mosi,
  output logic        cs_n,
  output logic [23:0] sample,
  output logic        sample_valid,
  output logic        cfg_error,
  output logic        streaming
);

  localparam int GAP_CLKS = 2 * CLK_DIV * CS_GAP;
  localparam int CW       = $clog2(GAP_CLKS + 1);

  localparam logic [2:0] F_RST = 3'd0, F_WR = 3'd1, F_RD = 3'd2,
                         F_GO  = 3'd3, F_DAT = 3'd4, F_STP = 3'd5;

  typedef enum logic [2:0] {S_IDLE, S_LEAD, S_HI, S_LO, S_GAP, S_WAIT} st_t;

  function automatic logic [7:0] cfg_byte(input logic [2:0] i);
    case (i)
      3'd0: return 8'h12;
      3'd1: return 8'h0A;
      3'd2: return 8'h14;
      3'd3: return 8'h12;
      3'd4: return 8'h07;
      default: return 8'hF0;
    endcase
  endfunction

  function automatic logic [7:0] tx_byte(input logic [2:0] f, input logic [2:0] i);
    case (f)
      F_RST: return 8'h06;
      F_WR:  return (i == 3'd0) ? 8'h42 : (i == 3'd1) ? 8'h05 : cfg_byte(i - 3'd2);
      F_RD:  return (i == 3'd0) ? 8'h22 : (i == 3'd1) ? 8'h05 : 8'h00;
      F_GO:  return 8'h08;
      F_DAT: return (i == 3'd0) ? 8'h12 : 8'h00;
      default: return 8'h0A;
    endcase
  endfunction

  function automatic logic tx_msb(input logic [2:0] f, input logic [2:0] i);
    logic [7:0] b;
    b = tx_byte(f, i);
    return b[7];
  endfunction

  function automatic logic [2:0] last_idx(input logic [2:0] f);
    case (f)
      F_WR, F_RD: return 3'd7;
      F_DAT:      return 3'd3;
      default:    return 3'd0;
    endcase
  endfunction

  st_t           st;
  logic [2:0]    frame, bidx, bit_n, sync;
  logic [CW-1:0] cnt;
  logic [6:0]    rx;
  logic [15:0]   acc;
  logic          pend, stop_pend;

  wire       half_done = (cnt == CW'(CLK_DIV - 1));
  wire       gap_done  = (cnt == CW'(GAP_CLKS - 1));
  wire       drdy_fall = sync[2] & ~sync[1];
  wire [7:0] cur       = tx_byte(frame, bidx);
  wire [7:0] rx_full   = {rx, miso};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; frame <= F_RST; bidx <= '0; bit_n <= '0; cnt <= '0;
      sync <= 3'b111; rx <= '0; acc <= '0; pend <= 1'b0; stop_pend <= 1'b0;
      sclk <= 1'b0; mosi <= 1'b0; cs_n <= 1'b1; sample <= '0;
      sample_valid <= 1'b0; cfg_error <= 1'b0; streaming <= 1'b0;
    end else begin
      sample_valid <= 1'b0;
      cnt  <= cnt + 1'b1;
      sync <= {sync[1:0], drdy_n};
      if (drdy_fall && streaming) pend <= 1'b1;
      if (stop_req && streaming) stop_pend <= 1'b1;
      case (st)
        S_IDLE: begin
          cnt <= '0;
          if (start_req && !cfg_error) begin
            frame <= F_RST; bidx <= '0; cs_n <= 1'b0; st <= S_LEAD;
          end
        end
        S_LEAD: if (half_done) begin
          cnt <= '0; sclk <= 1'b1; mosi <= cur[7]; bit_n <= '0; st <= S_HI;
        end
        S_HI: if (half_done) begin
          cnt <= '0; sclk <= 1'b0; rx <= rx_full[6:0]; st <= S_LO;
          if (bit_n == 3'd7) begin
            if (frame == F_RD && bidx >= 3'd2 && rx_full != cfg_byte(bidx - 3'd2))
              cfg_error <= 1'b1;
            if (frame == F_DAT && bidx != 3'd0) begin
              acc <= {acc[7:0], rx_full};
              if (bidx == 3'd3) begin
                sample <= {acc, rx_full};
                sample_valid <= 1'b1;
              end
            end
          end
        end
        S_LO: if (half_done) begin
          cnt <= '0;
          if (bit_n != 3'd7) begin
            bit_n <= bit_n + 3'd1; sclk <= 1'b1; mosi <= cur[3'd6 - bit_n]; st <= S_HI;
          end else if (bidx != last_idx(frame)) begin
            bidx <= bidx + 3'd1; bit_n <= '0; sclk <= 1'b1;
            mosi <= tx_msb(frame, bidx + 3'd1); st <= S_HI;
          end else begin
            cs_n <= 1'b1; st <= S_GAP;
          end
        end
        S_GAP: if (gap_done) begin
          cnt <= '0; bidx <= '0;
          case (frame)
            F_RST: begin frame <= F_WR; cs_n <= 1'b0; st <= S_LEAD; end
            F_WR:  begin frame <= F_RD; cs_n <= 1'b0; st <= S_LEAD; end
            F_RD:  if (cfg_error) st <= S_IDLE;
                   else begin frame <= F_GO; cs_n <= 1'b0; st <= S_LEAD; end
            F_GO:  begin streaming <= 1'b1; pend <= 1'b0; st <= S_WAIT; end
            F_DAT: st <= S_WAIT;
            default: st <= S_IDLE;
          endcase
        end
        S_WAIT: begin
          cnt <= '0;
          if (stop_pend) begin
            frame <= F_STP; stop_pend <= 1'b0; pend <= 1'b0; streaming <= 1'b0;
            cs_n <= 1'b0; st <= S_LEAD;
          end else if (pend) begin
            frame <= F_DAT; pend <= 1'b0; cs_n <= 1'b0; st <= S_LEAD;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [CW-1:0] hi_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n) hi_cnt <= CW'(GAP_CLKS);
    else if (!cs_n) hi_cnt <= '0;
    else if (hi_cnt != CW'(GAP_CLKS)) hi_cnt <= hi_cnt + 1'b1;
  end

  a_r11_cs_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> hi_cnt >= CW'(GAP_CLKS));
  a_r2_sclk_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);
  a_r2_mosi_rise_only: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !$rose(sclk)) |-> $stable(mosi));
  a_r8_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |=> !sample_valid);
  a_r8_valid_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |-> !cs_n);
  a_r9_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_error |=> cfg_error);
  a_r9_no_stream: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_error |-> !streaming);

endmodule

// File: tb/sim_adc_seq_host.sv
module sim_adc_seq_host;
  localparam int DIV = 2, GAP = 2;
  localparam int GAP_CLKS = 2 * DIV * GAP;

  logic clk = 1'b0, rst_n = 1'b0, start_req = 1'b0, stop_req = 1'b0;
  logic drdy_n = 1'b1, miso = 1'b0;
  logic sclk, mosi, cs_n, sample_valid, cfg_error, streaming;
  logic [23:0] sample;

  adc_seq_host #(.CLK_DIV(DIV), .CS_GAP(GAP)) u0 (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .stop_req(stop_req),
    .drdy_n(drdy_n), .miso(miso), .sclk(sclk), .mosi(mosi), .cs_n(cs_n),
    .sample(sample), .sample_valid(sample_valid), .cfg_error(cfg_error),
    .streaming(streaming));

  always #10 clk = ~clk;

  int n_chk = 0, n_bad = 0, frames_seen = 0;
  logic [63:0] exp_fr[$];
  int          exp_ln[$];
  string       exp_tag[$];
  logic [23:0] exp_smp[$];

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push(input string tag, input int len, input logic [63:0] data);
    exp_tag.push_back(tag); exp_ln.push_back(len); exp_fr.push_back(data);
  endtask

  // converter model
  logic [7:0]  regs [0:5];
  logic [63:0] rx_fr = '0;
  logic [7:0]  shin = '0, outb = '0;
  logic [23:0] adc_val = '0;
  int          nbits = 0;
  bit          corrupt = 1'b0;
  realtime     t_rise = -1.0;

  function automatic logic [7:0] resp(input int k);
    if (rx_fr[63:56] == 8'h22 && k >= 2 && k < 8) return regs[k-2];
    if (rx_fr[63:56] == 8'h12 && k >= 1 && k <= 3) return adc_val[(31 - 8*k) -: 8];
    return 8'h00;
  endfunction

  always @(negedge cs_n) begin
    nbits = 0; rx_fr = '0;
    if (t_rise >= 0.0)
      check(($realtime - t_rise) >= GAP_CLKS * 20.0, "R11 cs_n high time",
            64'(int'(($realtime - t_rise) / 20.0)), 64'(GAP_CLKS));
  end

  always @(posedge sclk) if (!cs_n) begin
    if (nbits % 8 == 0) outb = resp(nbits / 8);
    miso <= outb[7 - (nbits % 8)];
  end

  always @(negedge sclk) if (!cs_n) begin
    int k;
    shin = {shin[6:0], mosi};
    nbits++;
    if (nbits % 8 == 0) begin
      k = nbits / 8 - 1;
      if (k < 8) rx_fr[(63 - 8*k) -: 8] = shin;
      if (rx_fr[63:56] == 8'h42 && k >= 2 && k < 8)
        regs[k-2] = (corrupt && k == 4) ? (shin ^ 8'h01) : shin;
    end
  end

  // frame monitor
  always @(posedge cs_n) if (rst_n) begin
    frames_seen++;
    t_rise = $realtime;
    if (exp_fr.size() == 0) begin
      check(1'b0, "R7/R9/R10 unexpected frame", rx_fr, 64'h0);
    end else begin
      string tg;
      int ln;
      logic [63:0] d;
      tg = exp_tag.pop_front(); ln = exp_ln.pop_front(); d = exp_fr.pop_front();
      check(nbits == ln * 8, {tg, " frame length bits"}, 64'(nbits), 64'(ln * 8));
      check(rx_fr == d, {tg, " frame bytes"}, rx_fr, d);
    end
  end

  // sample monitor
  always @(negedge clk) if (rst_n && sample_valid) begin
    if (exp_smp.size() == 0) check(1'b0, "R8 unexpected sample", 64'(sample), 64'h0);
    else begin
      logic [23:0] e;
      e = exp_smp.pop_front();
      check(sample == e, "R8 sample value", 64'(sample), 64'(e));
    end
  end

  task automatic drain();
    wait (exp_fr.size() == 0 && exp_smp.size() == 0);
    repeat (40) @(negedge clk);
  endtask

  task automatic bring_up();
    push("R3", 1, 64'h0600000000000000);
    push("R4", 8, 64'h42_05_12_0A_14_12_07_F0);
    push("R5", 8, 64'h22_05_00_00_00_00_00_00);
    @(negedge clk) start_req = 1'b1;
    @(negedge clk) start_req = 1'b0;
  endtask

  task automatic read_one(input logic [23:0] v);
    adc_val = v;
    push("R7", 4, 64'h12000000_00000000);
    exp_smp.push_back(v);
    @(negedge clk) drdy_n = 1'b0;
    repeat (10) @(negedge clk);
    drdy_n = 1'b1;
    drain();
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int n;
    repeat (5) @(negedge clk);
    check(cs_n === 1'b1, "R1 cs_n", 64'(cs_n), 64'd1);
    check(sclk === 1'b0, "R1 sclk", 64'(sclk), 64'd0);
    check(sample_valid === 1'b0, "R1 sample_valid", 64'(sample_valid), 64'd0);
    check(cfg_error === 1'b0, "R1 cfg_error", 64'(cfg_error), 64'd0);
    check(streaming === 1'b0, "R1 streaming", 64'(streaming), 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    bring_up();
    push("R6", 1, 64'h0800000000000000);
    wait (streaming === 1'b1);
    drain();
    check(streaming === 1'b1, "R6 streaming", 64'(streaming), 64'd1);
    check(cfg_error === 1'b0, "R5 readback match", 64'(cfg_error), 64'd0);

    read_one(24'h123456);
    read_one(24'h800001);
    read_one(24'hFFFFFF);
    read_one(24'h7FFFFF);
    read_one(24'h000000);
    read_one(24'hA50F3C);

    // R10: stop raised during a read frame
    adc_val = 24'h5AA5C3;
    push("R10 read before stop", 4, 64'h12000000_00000000);
    exp_smp.push_back(24'h5AA5C3);
    push("R10", 1, 64'h0A00000000000000);
    @(negedge clk) drdy_n = 1'b0;
    @(negedge cs_n);
    @(negedge clk) stop_req = 1'b1;
    @(negedge clk) stop_req = 1'b0;
    drdy_n = 1'b1;
    drain();
    check(streaming === 1'b0, "R10 streaming after stop", 64'(streaming), 64'd0);

    // R10 and R7: stop_req and drdy_n edges ignored when not streaming
    n = frames_seen;
    @(negedge clk) stop_req = 1'b1;
    @(negedge clk) stop_req = 1'b0;
    repeat (5) @(negedge clk);
    drdy_n = 1'b0;
    repeat (10) @(negedge clk);
    drdy_n = 1'b1;
    repeat (200) @(negedge clk);
    check(frames_seen == n, "R10/R7 no frame while stopped", 64'(frames_seen), 64'(n));
    check(cs_n === 1'b1, "R7 cs_n idle", 64'(cs_n), 64'd1);

    // R9: readback mismatch
    corrupt = 1'b1;
    bring_up();
    drain();
    repeat (100) @(negedge clk);
    check(cfg_error === 1'b1, "R9 cfg_error set", 64'(cfg_error), 64'd1);
    check(streaming === 1'b0, "R9 no streaming", 64'(streaming), 64'd0);
    n = frames_seen;
    @(negedge clk) start_req = 1'b1;
    @(negedge clk) start_req = 1'b0;
    drdy_n = 1'b0;
    repeat (10) @(negedge clk);
    drdy_n = 1'b1;
    repeat (300) @(negedge clk);
    check(frames_seen == n, "R9 start ignored after error", 64'(frames_seen), 64'(n));
    check(cfg_error === 1'b1, "R9 cfg_error sticky", 64'(cfg_error), 64'd1);
    finish_run();
  end
endmodule